// File: doc/BRIEF.md
# Dual-Width One-Time-Programmable Memory Read Port

This block is a cycle-based model of a one-time-programmable memory as it is seen from its pins. It holds a 16-bit-wide array whose depth is a parameter. The array starts fully erased (every bit 1). A program operation can only clear bits. Reads are word-wide or byte-wide, chosen by a width-select input. In byte-wide operation an extra low address input picks which half of the addressed word is presented. In word-wide operation that pin is the data output for bit 15, so in byte-wide operation bit 15 is not driven.

Two active-low controls gate the output, and both must be low for data to appear. Chip enable acts as device select and standby control. Output enable gates the data onto the bus. The bus is modelled as a data vector plus one drive-enable per byte lane, so a high-impedance lane can be seen directly. Two digital flags stand in for high-voltage levels. One is the programming supply. The other is the high level on the identification address line, which returns a fixed manufacturer code or device code instead of array data. A program cycle is a falling chip enable while output enable is high and the programming supply flag is set.

Top module: `otp_port`

## Requirements
- R1: With chip enable and output enable both low, width select high and identification inactive, the edge after the inputs are applied presents the 16-bit word at `addr_i` on `q_o`, with `q_oe_o` = 2'b11.
- R2: With width select low, `lsb_i` = 0 presents bits 7..0 of the addressed word on `q_o[7:0]`, and `lsb_i` = 1 presents bits 15..8 there. `q_oe_o` = 2'b01 and `q_o[15:8]` reads 0.
- R3: While chip enable is high, the next output has `q_oe_o` = 2'b00 and `q_o` = 0, whatever level output enable has.
- R4: While chip enable is low and output enable is high, the next output has `q_oe_o` = 2'b00 and `q_o` = 0.
- R5: After reset every word of the array reads 16'hFFFF.
- R6: A sampled falling edge of chip enable, with output enable high and the programming supply flag set, stores the old word AND `d_i` at `addr_i`. All 16 bits are captured in one cycle.
- R7: Programming a 1 into a bit that already holds 0 leaves that bit 0.
- R8: A chip-enable falling edge while the programming supply flag is clear leaves the array unchanged.
- R9: With `id_hv_i` set and `addr_i` bits above bit 0 all zero, a read returns 8'h20 on bits 7..0 when `addr_i[0]` = 0, and 8'h32 when `addr_i[0]` = 1. Bits 15..8 read 0. If any higher address bit is set, the read returns array data.
- R10: With the programming supply flag still set, a read with both controls low (verify) returns the stored word and programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| wide_i | input | 1 | Width select: 1 word-wide, 0 byte-wide |
| vpp_i | input | 1 | Programming supply present flag |
| id_hv_i | input | 1 | High level present on the identification address line |
| addr_i | input | AW | Word address |
| lsb_i | input | 1 | Shared pin used as the byte-half address in byte mode |
| d_i | input | 16 | Data to program |
| q_o | output | 16 | Output data (0 in undriven lanes) |
| q_oe_o | output | 2 | Drive enable per byte lane: bit 0 for 7..0, bit 1 for 15..8 |

## Verification
Every read result is registered, so it appears one clock edge after the edge that samples the inputs. The bench applies inputs on the falling clock edge and samples one time unit after the next rising edge. A program is launched at the first rising edge where chip enable is seen low after having been seen high. That edge updates the array, so the read issued on the following falling edge already reflects the new word. Standby, output-disable and byte-lane states are checked through `q_oe_o` in that same next-edge slot.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  localparam logic [LANE_W-1:0] MFR_CODE = 8'h20;
  localparam logic [LANE_W-1:0] DEV_CODE = 8'h32;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_IDENT = 2'd2
  } src_e;

  // Cells only move from 1 to 0.
  function automatic word_t clear_merge(input word_t old_w, input word_t din);
    return old_w & din;
  endfunction

  function automatic lane_t half_of(input word_t w, input logic upper);
    return upper ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

  function automatic lane_t ident_code(input logic which);
    return which ? DEV_CODE : MFR_CODE;
  endfunction

endpackage

// File: rtl/otp_array.sv
module otp_array #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output otp_pkg::word_t rd_word,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  otp_pkg::word_t wr_word
);
  import otp_pkg::*;

  word_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) cells[i] <= '1;
    end else if (wr_fire) begin
      cells[wr_addr] <= clear_merge(cells[wr_addr], wr_word);
    end
  end

  assign rd_word = cells[rd_addr];

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          wide_i,
  input  logic          vpp_i,
  input  logic          id_hv_i,
  input  logic [AW-1:0] addr_i,
  output otp_pkg::src_e src,
  output logic [otp_pkg::LANES-1:0] lane_en,
  output logic          prog_fire
);
  import otp_pkg::*;

  logic ce_n_q;
  logic drive;
  logic id_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_n_q <= 1'b1;
    else        ce_n_q <= ce_n_i;
  end

  assign drive    = !ce_n_i && !oe_n_i;
  assign id_match = id_hv_i && (addr_i[AW-1:1] == '0);

  always_comb begin
    if (!drive)        src = SRC_NONE;
    else if (id_match) src = SRC_IDENT;
    else               src = SRC_ARRAY;
  end

  // Lane 0 always carries data when driving; upper lanes only when word-wide.
  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    if (g == 0) begin : g_low
      assign lane_en[g] = drive;
    end else begin : g_up
      assign lane_en[g] = drive && wide_i;
    end
  end

  assign prog_fire = vpp_i && oe_n_i && !ce_n_i && ce_n_q;

endmodule

// File: rtl/otp_outmux.sv
module otp_outmux (
  input  logic          clk,
  input  logic          rst_n,
  input  otp_pkg::src_e src,
  input  logic [otp_pkg::LANES-1:0] lane_en,
  input  logic          wide_i,
  input  logic          lsb_i,
  input  logic          id_sel,
  input  otp_pkg::word_t rd_word,
  output otp_pkg::word_t q_o,
  output logic [otp_pkg::LANES-1:0] q_oe_o
);
  import otp_pkg::*;

  lane_t lane_nxt [LANES];

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    always_comb begin
      lane_nxt[g] = '0;
      if (lane_en[g]) begin
        if (src == SRC_IDENT) begin
          lane_nxt[g] = (g == 0) ? ident_code(id_sel) : '0;
        end else if (src == SRC_ARRAY) begin
          if (g == 0 && !wide_i) lane_nxt[g] = half_of(rd_word, lsb_i);
          else                   lane_nxt[g] = rd_word[g*LANE_W +: LANE_W];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_o[g*LANE_W +: LANE_W] <= '0;
        q_oe_o[g]               <= 1'b0;
      end else begin
        q_o[g*LANE_W +: LANE_W] <= lane_nxt[g];
        q_oe_o[g]               <= lane_en[g];
      end
    end
  end

endmodule

// File: rtl/otp_port.sv
module otp_port #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          wide_i,
  input  logic          vpp_i,
  input  logic          id_hv_i,
  input  logic [AW-1:0] addr_i,
  input  logic          lsb_i,
  input  logic [15:0]   d_i,
  output logic [15:0]   q_o,
  output logic [1:0]    q_oe_o
);
  import otp_pkg::*;

  src_e             src;
  logic [LANES-1:0] lane_en;
  logic             prog_fire;
  word_t            rd_word;

  otp_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n_i   (ce_n_i),
    .oe_n_i   (oe_n_i),
    .wide_i   (wide_i),
    .vpp_i    (vpp_i),
    .id_hv_i  (id_hv_i),
    .addr_i   (addr_i),
    .src      (src),
    .lane_en  (lane_en),
    .prog_fire(prog_fire)
  );

  otp_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_i),
    .rd_word (rd_word),
    .wr_fire (prog_fire),
    .wr_addr (addr_i),
    .wr_word (d_i)
  );

  otp_outmux u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src),
    .lane_en (lane_en),
    .wide_i  (wide_i),
    .lsb_i   (lsb_i),
    .id_sel  (addr_i[0]),
    .rd_word (rd_word),
    .q_o     (q_o),
    .q_oe_o  (q_oe_o)
  );

endmodule

// File: rtl/otp_port_chk.sv
module otp_port_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n_i,
  input logic          oe_n_i,
  input logic          wide_i,
  input logic          vpp_i,
  input logic          id_hv_i,
  input logic [AW-1:0] addr_i,
  input logic [15:0]   q_o,
  input logic [1:0]    q_oe_o,
  input logic          prog_fire
);

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |=> (q_oe_o == 2'b00 && q_o == 16'h0)); // R3

  AST_OUTPUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && oe_n_i) |=> (q_oe_o == 2'b00)); // R4

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |=> (!q_oe_o[1] && q_o[15:8] == 8'h00)); // R2

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && !oe_n_i && wide_i) |=> (q_oe_o == 2'b11)); // R1

  AST_IDENT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (id_hv_i && addr_i[AW-1:1] == '0 && !ce_n_i && !oe_n_i) |=> (q_o[15:8] == 8'h00)); // R9

  AST_NO_PROG_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> (vpp_i && oe_n_i)); // R8

  AST_VERIFY_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_i |-> !prog_fire); // R10

endmodule

bind otp_port otp_port_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n_i   (ce_n_i),
  .oe_n_i   (oe_n_i),
  .wide_i   (wide_i),
  .vpp_i    (vpp_i),
  .id_hv_i  (id_hv_i),
  .addr_i   (addr_i),
  .q_o      (q_o),
  .q_oe_o   (q_oe_o),
  .prog_fire(prog_fire)
);

// File: tb/test_otp_port.sv
`timescale 1ns/1ps
module test_otp_port;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n_i = 1'b1, oe_n_i = 1'b1, wide_i = 1'b1;
  logic          vpp_i = 1'b0, id_hv_i = 1'b0, lsb_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   d_i = '0;
  logic [15:0]   q_o;
  logic [1:0]    q_oe_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  otp_port #(.DEPTH(DEPTH)) i_otp_port (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .wide_i(wide_i), .vpp_i(vpp_i), .id_hv_i(id_hv_i), .addr_i(addr_i),
    .lsb_i(lsb_i), .d_i(d_i), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got oe=%b q=%h expected oe=%b q=%h",
               req, got[17:16], got[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  // Apply read inputs on a falling edge; result is registered at the next rising edge.
  task automatic do_read(input logic [AW-1:0] a, input logic w, input logic l,
                         input logic ce, input logic oe, input logic vpp, input logic idf);
    @(negedge clk);
    addr_i = a; wide_i = w; lsb_i = l; ce_n_i = ce; oe_n_i = oe; vpp_i = vpp; id_hv_i = idf;
    @(posedge clk);
    #1;
  endtask

  task automatic do_program(input logic [AW-1:0] a, input logic [15:0] d, input logic vpp);
    @(negedge clk);
    id_hv_i = 1'b0; addr_i = a; d_i = d; vpp_i = vpp; oe_n_i = 1'b1; ce_n_i = 1'b1;
    @(negedge clk);
    ce_n_i = 1'b0;
    @(negedge clk);
    ce_n_i = 1'b1; vpp_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R3 reset idle", {q_oe_o, q_o}, 18'h0);
    do_read(8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 word0 erased", {q_oe_o, q_o}, {2'b11, 16'hFFFF});
    do_read(8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 last word erased", {q_oe_o, q_o}, {2'b11, 16'hFFFF});
  endtask

  task automatic t_program;
    do_program(8'd5, 16'h1234, 1'b1);
    do_read(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 program word", {q_oe_o, q_o}, {2'b11, 16'h1234});
    check("R1 word read", {q_oe_o, q_o}, {2'b11, 16'h1234});
    do_program(8'd5, 16'hFFF0, 1'b1);
    do_read(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 ones keep zeros", {q_oe_o, q_o}, {2'b11, 16'h1230});
    do_program(8'd6, 16'hA5C3, 1'b0);
    do_read(8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 no supply no write", {q_oe_o, q_o}, {2'b11, 16'hFFFF});
  endtask

  task automatic t_byte;
    do_read(8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 lower half", {q_oe_o, q_o}, {2'b01, 16'h0030});
    do_read(8'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 upper half", {q_oe_o, q_o}, {2'b01, 16'h0012});
  endtask

  task automatic t_controls;
    do_read(8'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 standby oe low", {q_oe_o, q_o}, 18'h0);
    do_read(8'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R3 standby oe high", {q_oe_o, q_o}, 18'h0);
    do_read(8'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R4 output disabled", {q_oe_o, q_o}, 18'h0);
  endtask

  task automatic t_verify;
    do_read(8'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    d_i = 16'h0000;
    do_read(8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 verify read", {q_oe_o, q_o}, {2'b11, 16'hFFFF});
    do_read(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 verify programmed", {q_oe_o, q_o}, {2'b11, 16'h1230});
    do_read(8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 verify left word", {q_oe_o, q_o}, {2'b11, 16'hFFFF});
  endtask

  task automatic t_ident;
    do_read(8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 maker code", {q_oe_o, q_o}, {2'b11, 16'h0020});
    do_read(8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 device code", {q_oe_o, q_o}, {2'b11, 16'h0032});
    do_read(8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 device code byte", {q_oe_o, q_o}, {2'b01, 16'h0032});
    do_read(8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 high addr bit array", {q_oe_o, q_o}, {2'b11, 16'h1230});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_program();
    t_byte();
    t_controls();
    t_verify();
    t_ident();
    finish_run();
  end

  initial begin
    #(5.0 * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule